// File: doc/BRIEF.md
# Coherent Dual-Parameter Transfer Engine

This block moves two channel parameters as one indivisible operation between a small two-word staging buffer and the shared data memory that holds channel parameters. Both regions live in the same single-port synchronous memory. A host issues one 32-bit control word. The word names the staging buffer location, the transfer direction and the transfer width. It also names two independent 7-bit parameter indices that share one 4-bit channel base, so the two parameters need not sit next to each other.

Once started, the engine walks a fixed sequence of word accesses over a request/ready memory port. For each parameter it reads the source word. In 24-bit mode it then also reads the destination word. Finally it writes the destination. A hold output stays high for the whole operation so that no other requester can touch the memory between the two parameters. A one-cycle done pulse marks the end.

Top module: `coh_param_mover`

## Requirements
- R1: When `ctlWe` is high while the engine is idle, the control word is taken at that clock edge, and `busy` and `hold` are high from the next cycle. Control word layout (bit 0 = LSB): [6:0] first index, [13:7] second index, [17:14] channel base, [18] direction, [19] width, [29:20] buffer base, [31:30] unused.
- R2: The byte address of a parameter is `MEM_BASE + {channel base, index, 2'b00}`, which is always word aligned.
- R3: The staging buffer starts at byte address `MEM_BASE + buffer base * 8`. The first parameter uses buffer word 0 (offset +0) and the second uses buffer word 1 (offset +4).
- R4: All accesses for the parameter picked by the first index complete before any access for the second.
- R5: Direction 0 copies parameter memory into the staging buffer. The parameter word is read and the buffer word is written.
- R6: Direction 1 copies the staging buffer into parameter memory. The buffer word is read and the parameter word is written.
- R7: Width 1 moves all 32 bits. Each parameter takes exactly two accesses: read the source, then write the destination with the source word.
- R8: Width 0 moves the low 24 bits by read-modify-write. Each parameter takes exactly three accesses: read the source, read the destination, then write `{dest[31:24], source[23:0]}`.
- R9: While `memReq` is high and `memReady` is low, `memReq`, `memAddr`, `memWe` and `memWdata` hold their values into the next cycle. An access completes at a clock edge where both are high, and read data is taken at that edge.
- R10: `busy` and `hold` stay high until the final write completes. `done` is high for exactly the one cycle after that edge, and `busy`, `hold` and `memReq` are low during that cycle.
- R11: A control write that arrives while `busy` is high is ignored. It adds no accesses and starts no operation.
- R12: After reset, `busy`, `hold`, `done` and `memReq` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctlWe | input | 1 | Control word write strobe |
| ctlData | input | 32 | Control word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| hold | output | 1 | Memory lock for other requesters |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write |
| memAddr | output | ADDR_W | Byte address |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with memReady |
| memReady | input | 1 | Access accepted at this edge |

## Verification
`busy` and `hold` are due one cycle after the control edge, so the bench checks them at the following falling edge. Each access is logged at the rising edge where request and ready are both high. `done` must appear in the cycle right after the edge that completes the final write, so the bench checks that its cycle stamp is exactly one more than the last access stamp and that `done` is gone one cycle later. The logged access list is compared in full against a sequential memory model after each operation. Stall stability is checked on every stalled edge against the previous cycle's values.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
  localparam int IDX_W  = 7;
  localparam int CHAN_W = 4;
  localparam int BASE_W = 10;

  localparam int IDX_A_LSB = 0;
  localparam int IDX_B_LSB = IDX_A_LSB + IDX_W;
  localparam int CHAN_LSB  = IDX_B_LSB + IDX_W;
  localparam int DIR_BIT   = CHAN_LSB + CHAN_W;
  localparam int WIDE_BIT  = DIR_BIT + 1;
  localparam int BASE_LSB  = WIDE_BIT + 1;
  localparam int CTL_USED  = BASE_LSB + BASE_W;

  localparam int PAR_OFS_W = CHAN_W + IDX_W + 2;
  localparam int BUF_OFS_W = BASE_W + 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RSRC = 2'd1,
    ST_RDST = 2'd2,
    ST_WDST = 2'd3
  } stepE;

  typedef struct packed {
    logic loadCtl;
    logic capSrc;
    logic capDst;
    logic second;
    logic atDest;
  } stepStrobesT;
endpackage

// File: rtl/cpm_ctrl.sv
module cpm_ctrl
  import cpm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctlWe,
  input  logic        wideMode,
  input  logic        memReady,
  output stepStrobesT st,
  output logic        memReq,
  output logic        memWe,
  output logic        busy,
  output logic        done
);
  stepE       state, stateD;
  logic       secondQ, secondD;
  logic       busyQ, doneQ;
  logic [2:0] accCnt;
  logic       lastWrite;

  assign lastWrite = (state == ST_WDST) && memReady && secondQ;

  always_comb begin
    st         = '0;
    st.second  = secondQ;
    st.atDest  = (state == ST_RDST) || (state == ST_WDST);
    st.loadCtl = (state == ST_IDLE) && ctlWe;
    st.capSrc  = (state == ST_RSRC) && memReady;
    st.capDst  = (state == ST_RDST) && memReady;
  end

  always_comb begin
    stateD  = state;
    secondD = secondQ;
    unique case (state)
      ST_IDLE: if (ctlWe) begin
        stateD  = ST_RSRC;
        secondD = 1'b0;
      end
      ST_RSRC: if (memReady) stateD = wideMode ? ST_WDST : ST_RDST;
      ST_RDST: if (memReady) stateD = ST_WDST;
      ST_WDST: if (memReady) begin
        if (secondQ) stateD = ST_IDLE;
        else begin
          stateD  = ST_RSRC;
          secondD = 1'b1;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      secondQ <= 1'b0;
      busyQ   <= 1'b0;
      doneQ   <= 1'b0;
      accCnt  <= '0;
    end else begin
      state   <= stateD;
      secondQ <= secondD;
      doneQ   <= lastWrite;
      if (st.loadCtl) busyQ <= 1'b1;
      else if (lastWrite) busyQ <= 1'b0;
      if (st.loadCtl) accCnt <= '0;
      else if (memReq && memReady) accCnt <= accCnt + 3'd1;
    end
  end

  assign memReq = (state != ST_IDLE);
  assign memWe  = (state == ST_WDST);
  assign busy   = busyQ;
  assign done   = doneQ;

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && !memReq));
  assert_hold_cover_R10: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);
  assert_ignore_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && ctlWe) |-> !st.loadCtl);
  assert_access_count_R8: assert property (@(posedge clk) disable iff (!rstN)
    lastWrite |-> (accCnt == (wideMode ? 3'd3 : 3'd5)));
endmodule

// File: rtl/cpm_datapath.sv
module cpm_datapath
  import cpm_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 32,
  parameter int KEEP_W = 24,
  parameter logic [ADDR_W-1:0] MEM_BASE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       ctlData,
  input  stepStrobesT       st,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              wideMode
);
  localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'((64'd1 << KEEP_W) - 64'd1);

  logic [CTL_USED-1:0] ctlQ;
  logic [DATA_W-1:0]   srcQ, dstQ;
  logic                unusedCtlHi;

  assign unusedCtlHi = ^ctlData[31:CTL_USED];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlQ <= '0;
      srcQ <= '0;
      dstQ <= '0;
    end else begin
      if (st.loadCtl) ctlQ <= ctlData[CTL_USED-1:0];
      if (st.capSrc)  srcQ <= memRdata;
      if (st.capDst)  dstQ <= memRdata;
    end
  end

  logic [IDX_W-1:0]     idxSel;
  logic [CHAN_W-1:0]    chanBase;
  logic [BASE_W-1:0]    bufBase;
  logic                 toParams;
  logic [PAR_OFS_W-1:0] parOfs;
  logic [BUF_OFS_W-1:0] bufOfs;
  logic [ADDR_W-1:0]    parAddr, bufAddr, srcAddr, dstAddr;

  assign idxSel   = st.second ? ctlQ[IDX_B_LSB +: IDX_W] : ctlQ[IDX_A_LSB +: IDX_W];
  assign chanBase = ctlQ[CHAN_LSB +: CHAN_W];
  assign bufBase  = ctlQ[BASE_LSB +: BASE_W];
  assign toParams = ctlQ[DIR_BIT];
  assign wideMode = ctlQ[WIDE_BIT];

  assign parOfs  = {chanBase, idxSel, 2'b00};
  assign bufOfs  = {bufBase, st.second, 2'b00};
  assign parAddr = MEM_BASE + ADDR_W'(parOfs);
  assign bufAddr = MEM_BASE + ADDR_W'(bufOfs);
  assign srcAddr = toParams ? bufAddr : parAddr;
  assign dstAddr = toParams ? parAddr : bufAddr;

  assign memAddr  = st.atDest ? dstAddr : srcAddr;
  assign memWdata = wideMode ? srcQ : ((srcQ & KEEP_MASK) | (dstQ & ~KEEP_MASK));
endmodule

// File: rtl/coh_param_mover.sv
module coh_param_mover
  import cpm_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 32,
  parameter int KEEP_W = 24,
  parameter logic [ADDR_W-1:0] MEM_BASE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlWe,
  input  logic [31:0]       ctlData,
  output logic              busy,
  output logic              done,
  output logic              hold,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memReady
);
  stepStrobesT st;
  logic        wideMode;

  cpm_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ctlWe    (ctlWe),
    .wideMode (wideMode),
    .memReady (memReady),
    .st       (st),
    .memReq   (memReq),
    .memWe    (memWe),
    .busy     (busy),
    .done     (done)
  );

  cpm_datapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .KEEP_W   (KEEP_W),
    .MEM_BASE (MEM_BASE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctlData  (ctlData),
    .st       (st),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .wideMode (wideMode)
  );

  assign hold = busy;

  assert_stall_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata)));
  assert_word_aligned_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[1:0] == MEM_BASE[1:0]));
endmodule

// File: tb/tb_coh_param_mover.sv
module tb_coh_param_mover;
  localparam int AW = 14;
  localparam logic [AW-1:0] BASE = 14'h0800;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctlWe = 1'b0;
  logic [31:0] ctlData = '0;
  logic busy, done, hold, memReq, memWe, memReady;
  logic [AW-1:0] memAddr;
  logic [31:0] memWdata, memRdata;

  always #2 clk = ~clk;

  coh_param_mover #(.ADDR_W(AW), .MEM_BASE(BASE)) dut (
    .clk(clk), .rstN(rstN), .ctlWe(ctlWe), .ctlData(ctlData),
    .busy(busy), .done(done), .hold(hold), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .memReady(memReady)
  );

  logic [31:0] mem   [4096];
  logic [31:0] model [4096];
  int readyPct = 100;
  int vecs = 0, errs = 0;

  logic        logWe   [16];
  logic [AW-1:0] logAddr [16];
  logic [31:0] logData [16];
  int logN = 0;
  int cyc = 0, lastAcc = 0;
  int stallErrs = 0;
  logic prevStall = 1'b0, pReq, pWe;
  logic [AW-1:0] pAddr;
  logic [31:0] pData;

  logic        expWe   [16];
  logic [AW-1:0] expAddr [16];
  logic [31:0] expData [16];
  int expN;

  assign memRdata = memReady ? mem[memAddr[AW-1:2]] : 32'hDEAD_BEEF;

  always @(negedge clk) memReady <= (($urandom % 100) < readyPct);

  always @(posedge clk) begin
    if (rstN && prevStall &&
        (!memReq || memAddr != pAddr || memWe != pWe || memWdata != pData))
      stallErrs++;
    prevStall = memReq && !memReady;
    pReq = memReq; pWe = memWe; pAddr = memAddr; pData = memWdata;
    if (rstN && memReq && memReady) begin
      if (logN < 16) begin
        logWe[logN] = memWe; logAddr[logN] = memAddr; logData[logN] = memWdata;
      end
      logN++;
      lastAcc = cyc;
      if (memWe) mem[memAddr[AW-1:2]] = memWdata;
    end
    cyc = cyc + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic we, input logic [AW-1:0] a, input logic [31:0] d);
    expWe[expN] = we; expAddr[expN] = a; expData[expN] = d; expN++;
  endtask

  function automatic logic [31:0] mkWord(input logic [9:0] bb, input logic wide, input logic dir,
                                         input logic [3:0] ch, input logic [6:0] ib, input logic [6:0] ia);
    return {2'b00, bb, wide, dir, ch, ib, ia};
  endfunction

  task automatic buildExpect(input logic [31:0] w);
    expN = 0;
    for (int p = 0; p < 2; p++) begin
      logic [6:0] idx;
      logic [AW-1:0] pa, ba, src, dst;
      logic [31:0] v;
      idx = (p == 1) ? w[13:7] : w[6:0];
      pa  = BASE + AW'({w[17:14], idx, 2'b00});
      ba  = BASE + AW'({w[29:20], p[0], 2'b00});
      src = w[18] ? ba : pa;
      dst = w[18] ? pa : ba;
      push(1'b0, src, 32'h0);
      if (!w[19]) push(1'b0, dst, 32'h0);
      v = w[19] ? model[src[AW-1:2]] : {model[dst[AW-1:2]][31:24], model[src[AW-1:2]][23:0]};
      push(1'b1, dst, v);
      model[dst[AW-1:2]] = v;
    end
  endtask

  task automatic runOp(input logic [31:0] w, input bit tryIgnore);
    string wr;
    int waitc;
    wr = w[19] ? "R7" : "R8";
    buildExpect(w);
    @(negedge clk);
    logN = 0;
    ctlWe = 1'b1; ctlData = w;
    @(negedge clk);
    ctlWe = 1'b0;
    check(busy === 1'b1 && hold === 1'b1, "R1", "busy/hold after start", {hold, busy}, 32'h3);
    if (tryIgnore && !done) begin
      ctlWe = 1'b1; ctlData = ~w;
      @(negedge clk);
      ctlWe = 1'b0;
    end
    waitc = 0;
    while (done !== 1'b1 && waitc < 500) begin
      @(negedge clk);
      waitc++;
    end
    check(waitc < 500, "R10", "done seen", waitc, 0);
    check(busy === 1'b0 && hold === 1'b0 && memReq === 1'b0, "R10", "idle with done",
          {busy, hold, memReq}, 0);
    check(cyc == lastAcc + 1, "R10", "done one cycle after final write", cyc, lastAcc + 1);
    check(logN == expN, tryIgnore ? "R11" : wr, "access count", logN, expN);
    for (int i = 0; i < expN && i < logN; i++) begin
      check(logAddr[i] == expAddr[i], "R4", "access address/order (R2 R3)",
            32'(logAddr[i]), 32'(expAddr[i]));
      check(logWe[i] == expWe[i], w[18] ? "R6" : "R5", "access direction",
            32'(logWe[i]), 32'(expWe[i]));
      if (expWe[i]) check(logData[i] == expData[i], wr, "write data", logData[i], expData[i]);
    end
    @(negedge clk);
    check(done === 1'b0, "R10", "done single cycle", done, 0);
    if (tryIgnore)
      check(busy === 1'b0 && logN == expN, "R11", "ignored write started nothing", logN, expN);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4096; i++) begin
      mem[i] = $urandom;
      model[i] = mem[i];
    end
    repeat (4) @(negedge clk);
    check(busy === 1'b0 && hold === 1'b0 && done === 1'b0 && memReq === 1'b0,
          "R12", "reset outputs", {busy, hold, done, memReq}, 0);
    rstN = 1'b1;
    @(negedge clk);
    // zero wait state, directed corners
    readyPct = 100;
    runOp(mkWord(10'd5, 1'b1, 1'b0, 4'd3, 7'd9, 7'd100), 1'b0);    // R5 R7 non-contiguous
    runOp(mkWord(10'd5, 1'b1, 1'b1, 4'd3, 7'd9, 7'd100), 1'b0);    // R6 R7
    runOp(mkWord(10'd7, 1'b0, 1'b0, 4'd15, 7'd127, 7'd0), 1'b0);   // R5 R8
    runOp(mkWord(10'd1023, 1'b0, 1'b1, 4'd0, 7'd2, 7'd2), 1'b0);   // R6 R8 same index
    // stalled memory
    readyPct = 40;
    runOp(mkWord(10'd300, 1'b0, 1'b1, 4'd8, 7'd64, 7'd1), 1'b1);   // R11 during busy
    runOp(mkWord(10'd0, 1'b1, 1'b0, 4'd1, 7'd0, 7'd127), 1'b1);
    for (int n = 0; n < 40; n++) begin
      logic [31:0] w;
      readyPct = 30 + ($urandom % 71);
      w = mkWord(10'($urandom), 1'($urandom), 1'($urandom), 4'($urandom), 7'($urandom), 7'($urandom));
      runOp(w, (n % 5) == 0);
    end
    check(stallErrs == 0, "R9", "signals stable under stall", stallErrs, 0);
    for (int i = 0; i < 4096; i++)
      if (mem[i] !== model[i]) begin
        check(1'b0, "R8", "final memory image", mem[i], model[i]);
        break;
      end
    vecs++;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    vecs++;
    $display("FAIL watchdog expired: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule